// File: doc/BRIEF.md
# Neuron Configuration Port Decoder

This block is the reconfiguration front end that sits beside each neuron of an array of identical processing neurons. All neurons listen to one shared configuration bus that carries a neuron-select code, a word address and a 16-bit data word. A neuron accepts a write only when the select code equals its own strapped identifier and that identifier is one of the neurons that can exist in the array. An accepted write lands in the neuron's 256-word by 16-bit program store. The neuron's controller keeps fetching instructions from a second, independent read port throughout, so program rewriting happens live and leaves every other neuron untouched.

The block also drives the neuron's input multiplexer, which picks one of 30 byte-wide sources: primary inputs and the outputs of other neurons. Its select value sits in a register loaded from configuration data. A write that is accepted at the reserved top word address stores the word in the program store as usual. In the same edge, the low five bits of that word are copied into the select register. The program can therefore read its own routing word back. Select codes with no source behind them drive the neuron input to zero.

Top module: `ncfg_port_decoder`

## Requirements
- R1: While rst_n is low at a rising edge, the fetch output becomes 0 and the source select register becomes 0, so after reset nrn_in equals source lane 0 (bits 7:0 of src_in).
- R2: When cfg_en is 1, cfg_sel equals node_id and node_id is below 28 at a rising edge, cfg_data is stored at word cfg_addr of the program store.
- R3: fetch_instr presents the word at fetch_addr one clock after the address is applied (one registered stage).
- R4: When a write and a fetch target the same word in the same cycle, fetch_instr returns the word held before the write; the new word appears on the next fetch.
- R5: With cfg_en low, or with cfg_sel different from node_id, the program store and the source select register keep their contents.
- R6: Select codes 28 to 31 never write, even when node_id holds the same value.
- R7: An accepted write to word address 255 also loads cfg_data bits 4:0 into the source select register. For a select value k from 0 to 29, nrn_in then equals src_in bits 8k+7:8k. Writes to other addresses leave the select unchanged.
- R8: A source select value of 30 or 31 forces nrn_in to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| node_id | input | 5 | Strapped identifier of this neuron |
| cfg_en | input | 1 | Configuration write strobe on the shared bus |
| cfg_sel | input | 5 | Neuron-select code on the shared bus |
| cfg_addr | input | 8 | Program word address on the shared bus |
| cfg_data | input | 16 | Program word on the shared bus |
| fetch_addr | input | 8 | Instruction fetch address from the neuron controller |
| fetch_instr | output | 16 | Registered instruction word to the neuron controller |
| src_in | input | 240 | 30 byte-wide candidate inputs, lane k at bits 8k+7:8k |
| nrn_in | output | 8 | Selected neuron input byte |

## Verification
The bench builds the block with its default parameters: 28 neurons, 30 sources of 8 bits, a 256-word store and the routing word at address 255. With these values the out-of-range identifiers 28 to 31 and the two unused select codes 30 and 31 fall within the 5-bit fields and can be driven. Because node_id is a port, the bench can move the neuron's identity during the run. It takes it to the last valid identifier 27 and to the invalid 29, and it collides a fetch with a write on the same word so that read-first ordering is observable. A long mixed stream of foreign, disabled and accepted writes then runs against the behavioural model.

// File: rtl/ncfg_pkg.sv
// Shared defaults and helpers for the neuron configuration port decoder.
// Assumes: identifiers are compared as unsigned codes.
package ncfg_pkg;
    localparam int DEF_DATA_W    = 16;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_SEL_W     = 5;
    localparam int DEF_NODES     = 28;
    localparam int DEF_SOURCES   = 30;
    localparam int DEF_SRC_W     = 8;
    localparam int DEF_ROUTE_ADR = 255;

    // True when an identifier names a neuron that can exist in the array.
    function automatic logic id_is_live(input logic [7:0] id, input int count);
        return int'(id) < count;
    endfunction
endpackage

// File: rtl/ncfg_write_gate.sv
// Decodes the shared configuration bus for one neuron.
// Produces the program-store write strobe and the routing-register load.
// Assumes: all inputs are synchronous to the neuron clock.
module ncfg_write_gate #(
    parameter int SEL_W     = ncfg_pkg::DEF_SEL_W,
    parameter int ADDR_W    = ncfg_pkg::DEF_ADDR_W,
    parameter int NODES     = ncfg_pkg::DEF_NODES,
    parameter int ROUTE_ADR = ncfg_pkg::DEF_ROUTE_ADR
) (
    input  logic              cfg_en,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [SEL_W-1:0]  node_id,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic              wr_hit,
    output logic              route_load
);
    localparam logic [ADDR_W-1:0] ROUTE_A = ADDR_W'(ROUTE_ADR);

    logic id_live;

    // Identifier range check against the number of neurons in the array.
    always_comb id_live = ncfg_pkg::id_is_live(8'(node_id), NODES);

    // Write strobe: enabled, addressed to us, and we are a real neuron.
    always_comb wr_hit = cfg_en && (cfg_sel == node_id) && id_live;

    // Routing load: accepted write landing on the reserved routing word.
    always_comb route_load = wr_hit && (cfg_addr == ROUTE_A);
endmodule

// File: rtl/ncfg_prog_store.sv
// Dual-port program store: one write port, one registered read port.
// Read-first: a same-address collision returns the previous word.
// Assumes: contents are undefined until written; only the read register resets.
module ncfg_prog_store #(
    parameter int DATA_W = ncfg_pkg::DEF_DATA_W,
    parameter int ADDR_W = ncfg_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Write port: commit the configuration word on the clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Read port: register the addressed word (sees the pre-write value).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= words[raddr];
        end
    end
endmodule

// File: rtl/ncfg_src_mux.sv
// Source selector for the neuron input: a select register plus an N-to-1 mux.
// Select codes with no source behind them yield zero.
// Assumes: src_in packs lane k at bits k*SRC_W +: SRC_W.
module ncfg_src_mux #(
    parameter int SOURCES = ncfg_pkg::DEF_SOURCES,
    parameter int SRC_W   = ncfg_pkg::DEF_SRC_W,
    parameter int MSEL_W  = $clog2(SOURCES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [MSEL_W-1:0]        load_val,
    input  logic [SOURCES*SRC_W-1:0] src_in,
    output logic [MSEL_W-1:0]        sel_q,
    output logic [SRC_W-1:0]         y
);
    logic [SRC_W-1:0] lane [SOURCES];

    // Select register: resets to source 0, reloads from configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (load) begin
            sel_q <= load_val;
        end
    end

    // Unpack the source bus into lanes.
    for (genvar g = 0; g < SOURCES; g++) begin : g_lane
        assign lane[g] = src_in[g*SRC_W +: SRC_W];
    end

    // One-hot style selection; an unmatched code leaves the output at zero.
    always_comb begin
        y = '0;
        for (int i = 0; i < SOURCES; i++) begin
            if (sel_q == MSEL_W'(i)) begin
                y = lane[i];
            end
        end
    end
endmodule

// File: rtl/ncfg_port_decoder.sv
// Per-neuron configuration port decoder (top).
// Gates the shared configuration bus onto this neuron's program store and
// input-source select register while the neuron keeps fetching instructions.
// Assumes: node_id is quasi-static; all inputs synchronous to clk.
module ncfg_port_decoder #(
    parameter int DATA_W    = ncfg_pkg::DEF_DATA_W,
    parameter int ADDR_W    = ncfg_pkg::DEF_ADDR_W,
    parameter int SEL_W     = ncfg_pkg::DEF_SEL_W,
    parameter int NODES     = ncfg_pkg::DEF_NODES,
    parameter int SOURCES   = ncfg_pkg::DEF_SOURCES,
    parameter int SRC_W     = ncfg_pkg::DEF_SRC_W,
    parameter int ROUTE_ADR = ncfg_pkg::DEF_ROUTE_ADR
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         node_id,
    input  logic                     cfg_en,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_data,
    input  logic [ADDR_W-1:0]        fetch_addr,
    output logic [DATA_W-1:0]        fetch_instr,
    input  logic [SOURCES*SRC_W-1:0] src_in,
    output logic [SRC_W-1:0]         nrn_in
);
    localparam int MSEL_W = $clog2(SOURCES);

    logic              wr_hit;
    logic              route_load;
    logic [MSEL_W-1:0] mux_sel_q;

    ncfg_write_gate #(
        .SEL_W(SEL_W), .ADDR_W(ADDR_W), .NODES(NODES), .ROUTE_ADR(ROUTE_ADR)
    ) u_gate (
        .cfg_en(cfg_en), .cfg_sel(cfg_sel), .node_id(node_id),
        .cfg_addr(cfg_addr), .wr_hit(wr_hit), .route_load(route_load)
    );

    ncfg_prog_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_hit), .waddr(cfg_addr),
        .wdata(cfg_data), .raddr(fetch_addr), .rdata(fetch_instr)
    );

    ncfg_src_mux #(.SOURCES(SOURCES), .SRC_W(SRC_W), .MSEL_W(MSEL_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .load(route_load),
        .load_val(cfg_data[MSEL_W-1:0]), .src_in(src_in),
        .sel_q(mux_sel_q), .y(nrn_in)
    );
endmodule

// File: rtl/ncfg_port_decoder_chk.sv
// Assertion checker for the configuration port decoder, bound to the top.
module ncfg_port_decoder_chk #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int SEL_W     = 5,
    parameter int NODES     = 28,
    parameter int MSEL_W    = 5,
    parameter int ROUTE_ADR = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [SEL_W-1:0]  node_id,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              wr_hit,
    input logic [MSEL_W-1:0] sel_q,
    input logic [DATA_W-1:0] fetch_instr
);
    // Reset clears the fetch register and the source select.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (fetch_instr == '0 && sel_q == '0));

    // An addressed, enabled write to a live neuron must fire.
    assert_write_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_sel == node_id && int'(node_id) < NODES) |-> wr_hit);

    // Disabled or foreign traffic never writes.
    assert_foreign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en || cfg_sel != node_id) |-> !wr_hit);

    // Out-of-range select codes never write.
    assert_range_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_sel) >= NODES) |-> !wr_hit);

    // The select register only moves on an accepted routing-word write.
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && cfg_addr == ADDR_W'(ROUTE_ADR)) |=> $stable(sel_q));
endmodule

bind ncfg_port_decoder ncfg_port_decoder_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NODES(NODES),
    .MSEL_W(MSEL_W), .ROUTE_ADR(ROUTE_ADR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .node_id(node_id), .cfg_addr(cfg_addr), .wr_hit(wr_hit),
    .sel_q(mux_sel_q), .fetch_instr(fetch_instr)
);

// File: tb/sim_ncfg_port_decoder.sv
// Self-checking bench with a behavioural per-cycle reference model.
module sim_ncfg_port_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   node_id = 5'd5;
    logic         cfg_en = 1'b0;
    logic [4:0]   cfg_sel = '0;
    logic [7:0]   cfg_addr = '0;
    logic [15:0]  cfg_data = '0;
    logic [7:0]   fetch_addr = '0;
    logic [15:0]  fetch_instr;
    logic [239:0] src_in;
    logic [7:0]   nrn_in;

    int total = 0;
    int bad = 0;
    string tag = "R1 reset";

    // reference model state
    logic [15:0] mm [256];
    bit          kn [256];
    logic [15:0] exp_q;
    bit          exp_qk;
    logic [4:0]  exp_sel;
    logic [7:0]  exp_y;

    always #10 clk = ~clk; // 50 MHz

    ncfg_port_decoder u0 (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .cfg_en(cfg_en),
        .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
        .src_in(src_in), .nrn_in(nrn_in)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", t, act, exp);
        end
    endtask

    // Model update at each edge, then compare a little after the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q = '0; exp_qk = 1'b1; exp_sel = '0;
        end else begin
            exp_qk = kn[fetch_addr];
            exp_q  = mm[fetch_addr];
            if (cfg_en && cfg_sel == node_id && node_id < 5'd28) begin
                mm[cfg_addr] = cfg_data;
                kn[cfg_addr] = 1'b1;
                if (cfg_addr == 8'd255) exp_sel = cfg_data[4:0];
            end
        end
        #4;
        if (exp_qk) chk(fetch_instr === exp_q, {tag, " fetch"}, fetch_instr, exp_q);
        exp_y = (exp_sel < 5'd30) ? src_in[exp_sel*8 +: 8] : 8'h00;
        chk(nrn_in === exp_y, {tag, " mux"}, nrn_in, exp_y);
    end

    task automatic cyc(input logic en, input logic [4:0] s, input logic [7:0] a,
                       input logic [15:0] d, input logic [7:0] fa);
        @(negedge clk);
        cfg_en = en; cfg_sel = s; cfg_addr = a; cfg_data = d; fetch_addr = fa;
    endtask

    task automatic fill_src(input int k);
        for (int i = 0; i < 30; i++) src_in[i*8 +: 8] = 8'((i * 13 + k) & 255);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) kn[i] = 1'b0;
        fill_src(5);
        // R1 reset
        repeat (3) @(negedge clk);
        chk(fetch_instr === 16'h0, "R1 fetch after reset", fetch_instr, 0);
        chk(nrn_in === src_in[7:0], "R1 lane0 after reset", nrn_in, src_in[7:0]);
        rst_n = 1'b1;
        // R2 fill words 0..15
        tag = "R2 write";
        for (int i = 0; i < 16; i++) cyc(1, 5, 8'(i), 16'(16'hA000 + i * 3), 0);
        // R3 fetch back with one-cycle latency
        tag = "R3 latency";
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 8'(i));
        cyc(0, 0, 0, 0, 8'd7);
        @(negedge clk);
        chk(fetch_instr === 16'hA015, "R3 word 7", fetch_instr, 16'hA015);
        // R5 foreign and disabled writes
        tag = "R5 mismatch";
        cyc(1, 6, 3, 16'hDEAD, 3);
        cyc(0, 5, 3, 16'hBEEF, 3);
        cyc(0, 0, 0, 0, 3);
        @(negedge clk);
        chk(fetch_instr === 16'hA009, "R5 word 3 kept", fetch_instr, 16'hA009);
        // R4 collision
        tag = "R4 read-first";
        cyc(1, 5, 3, 16'h1234, 3);
        @(negedge clk);
        chk(fetch_instr === 16'hA009, "R4 old word", fetch_instr, 16'hA009);
        cyc(0, 0, 0, 0, 3);
        @(negedge clk);
        chk(fetch_instr === 16'h1234, "R4 new word", fetch_instr, 16'h1234);
        // R7 routing
        tag = "R7 mux load";
        cyc(1, 5, 255, 16'h000C, 0);
        cyc(0, 0, 0, 0, 0);
        chk(nrn_in === src_in[12*8 +: 8], "R7 lane 12", nrn_in, src_in[12*8 +: 8]);
        cyc(1, 5, 254, 16'h0003, 0);
        cyc(0, 0, 0, 0, 0);
        chk(nrn_in === src_in[12*8 +: 8], "R7 other addr holds", nrn_in, src_in[12*8 +: 8]);
        cyc(1, 5, 255, 16'hFFFD, 0);
        cyc(0, 0, 0, 0, 0);
        chk(nrn_in === src_in[29*8 +: 8], "R7 lane 29", nrn_in, src_in[29*8 +: 8]);
        // R8 unused codes
        tag = "R8 mux zero";
        cyc(1, 5, 255, 16'h001E, 0);
        cyc(0, 0, 0, 0, 0);
        chk(nrn_in === 8'h00, "R8 code 30", nrn_in, 0);
        cyc(1, 5, 255, 16'h003F, 0);
        cyc(0, 0, 0, 0, 0);
        chk(nrn_in === 8'h00, "R8 code 31", nrn_in, 0);
        // R6 out-of-range identifier
        tag = "R6 range";
        node_id = 5'd29;
        cyc(1, 29, 4, 16'h5555, 4);
        cyc(1, 29, 255, 16'h0002, 4);
        cyc(0, 0, 0, 0, 4);
        @(negedge clk);
        chk(fetch_instr === 16'hA00C, "R6 word 4 kept", fetch_instr, 16'hA00C);
        chk(nrn_in === 8'h00, "R6 select kept", nrn_in, 0);
        node_id = 5'd27;
        cyc(1, 27, 4, 16'h7777, 4);
        cyc(0, 0, 0, 0, 4);
        @(negedge clk);
        chk(fetch_instr === 16'h7777, "R2 id 27 accepted", fetch_instr, 16'h7777);
        // mixed stream
        tag = "R2/R5/R7 stream";
        for (int n = 0; n < 600; n++) begin
            logic [4:0] s;
            s = ($urandom % 3 == 0) ? 5'($urandom) : 5'd27;
            cyc(1'($urandom), s, ($urandom % 4 == 0) ? 8'd255 : 8'($urandom % 24),
                16'($urandom), 8'($urandom % 24));
            if (n % 50 == 0) fill_src(n);
        end
        cyc(0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule